// File: doc/BRIEF.md
# Prescaled 8-bit Reload Timer

This block is an 8-bit up-counter for a microcontroller peripheral set. It advances on a count enable taken from one of seven taps of a free-running 13-bit prescaler, or from an edge on an external event pin. The event pin is synchronized to the system clock, and a mode bit picks the active edge. When the counter passes 0xFF it either returns to zero or takes a programmable reload value, depending on a mode bit. Each overflow sets a sticky interrupt request flag, which software clears by writing 0.

A small register bus gives access to the block. Address 0 holds the mode register. Address 1 reads back the live count, and a write to it goes to the reload register, so the count can never be written from the bus. Address 2 holds the flag. Reads are combinational and writes take effect on the next clock edge.

Top module: `reload_timer8`

## Requirements
- R1: After reset the count is 0x00, the mode register reads 0x00 (source code 000, wrap mode, rising edge), and the flag and irqFlag are 0.
- R2: Mode bits [2:0] select the count source. Codes 000, 001, 010, 011, 100, 101 and 110 give exactly one increment every 8192, 2048, 512, 256, 64, 16 and 4 system clocks.
- R3: Code 111 counts edges of evtIn after a two-flop synchronizer. Mode bit 4 = 0 counts rising edges and mode bit 4 = 1 counts falling edges. The count changes on the third rising clock edge after evtIn changes, and the opposite edge is not counted.
- R4: A bus write to address 1 loads the reload register and leaves the count unchanged. The count is never written from the bus.
- R5: With mode bit 3 = 0 (wrap mode), an increment from 0xFF gives 0x00.
- R6: With mode bit 3 = 1 (auto-reload mode), an increment from 0xFF loads the reload register value.
- R7: Every overflow sets the flag, which reads as bit 0 of address 2 and drives irqFlag.
- R8: Writing 0 to bit 0 of address 2 clears the flag. Writing 1 to that bit has no effect.
- R9: When an overflow and a clearing write happen in the same cycle, the flag ends up set.
- R10: Address 0 reads {3'b000, edge bit 4, reload bit 3, source [2:0]}. Address 1 reads the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 1 | External event input, asynchronous |
| busAddr | input | 2 | Register address |
| busWr | input | 1 | Write strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr |
| irqFlag | output | 1 | Sticky overflow request |

## Verification
The hardest case to reach is an overflow that lands on the same clock edge as a clearing write to the flag. The prescaler's phase is not visible at the ports, so the bench switches to the external event source and walks the count to 0xFF one event at a time. It then raises evtIn and places the clearing write exactly two clock edges later, which lines it up with the synchronizer's third-edge count. The prescaler taps are checked over windows that are whole multiples of each division, so each result is exact whatever the prescaler phase.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
  localparam int CNT_W    = 8;
  localparam int PRESC_W  = 13;
  localparam int SEL_W    = 3;
  localparam int ADDR_W   = 2;
  localparam int NUM_TAPS = 7;
  localparam int MODE_W   = 5;
  localparam int MODE_RELOAD_BIT = 3;
  localparam int MODE_EDGE_BIT   = 4;
  // prescaler bit whose rising transition is each tap's tick, codes 0..6
  localparam int TAP_BIT [NUM_TAPS] = '{12, 10, 8, 7, 5, 3, 1};
  localparam logic [ADDR_W-1:0] ADDR_MODE  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_COUNT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_FLAG  = ADDR_W'(2);

  typedef struct packed {
    logic countEn;
    logic wrMode;
    logic wrReload;
    logic clrFlag;
  } tmrStrobes_t;
endpackage

// File: rtl/rtmr_ctrl.sv
module rtmr_ctrl
  import rtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busWdata0,
  input  logic [SEL_W-1:0]  clkSel,
  input  logic              fallEdge,
  output tmrStrobes_t       stb
);
  localparam int SRC_N = 1 << SEL_W;

  logic [PRESC_W-1:0] presc;
  logic syncA, syncB, syncPrev;
  logic [NUM_TAPS-1:0] tapTick;
  logic [SRC_N-1:0] srcVec;
  logic extTick;

  always_ff @(posedge clk) begin
    if (!rstN) presc <= '0;
    else       presc <= presc + 1'b1;
  end

  // tick in the cycle before the tap bit rises, so the increment lands on that edge
  for (genvar i = 0; i < NUM_TAPS; i++) begin : g_tap
    localparam int B = TAP_BIT[i];
    localparam logic [PRESC_W-1:0] PAT = PRESC_W'((1 << B) - 1);
    assign tapTick[i] = (presc[B:0] == PAT[B:0]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncA <= 1'b0; syncB <= 1'b0; syncPrev <= 1'b0;
    end else begin
      syncA <= evtIn; syncB <= syncA; syncPrev <= syncB;
    end
  end

  assign extTick = fallEdge ? (!syncB && syncPrev) : (syncB && !syncPrev);
  assign srcVec  = {extTick, tapTick};

  always_comb begin
    stb.countEn  = srcVec[clkSel];
    stb.wrMode   = busWr && (busAddr == ADDR_MODE);
    stb.wrReload = busWr && (busAddr == ADDR_COUNT);
    stb.clrFlag  = busWr && (busAddr == ADDR_FLAG) && !busWdata0;
  end

  // prescaler ticks never come on back-to-back cycles while the source is unchanged
  p_single_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countEn && clkSel != SEL_W'(SRC_N - 1)) |=> (!stb.countEn || clkSel != $past(clkSel)));
endmodule

// File: rtl/rtmr_datapath.sv
module rtmr_datapath
  import rtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobes_t       stb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [SEL_W-1:0]  clkSel,
  output logic              fallEdge,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irqFlag
);
  logic [MODE_W-1:0] modeReg;
  logic [CNT_W-1:0]  count, reloadReg;
  logic flag, reloadMode, overflow;

  assign clkSel     = modeReg[SEL_W-1:0];
  assign reloadMode = modeReg[MODE_RELOAD_BIT];
  assign fallEdge   = modeReg[MODE_EDGE_BIT];
  assign overflow   = stb.countEn && (count == '1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg   <= '0;
      reloadReg <= '0;
    end else begin
      if (stb.wrMode)   modeReg   <= busWdata[MODE_W-1:0];
      if (stb.wrReload) reloadReg <= busWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 count <= '0;
    else if (overflow)         count <= reloadMode ? reloadReg : '0;
    else if (stb.countEn)      count <= count + 1'b1;
  end

  // overflow has priority over a clearing write
  always_ff @(posedge clk) begin
    if (!rstN)             flag <= 1'b0;
    else if (overflow)     flag <= 1'b1;
    else if (stb.clrFlag)  flag <= 1'b0;
  end

  assign irqFlag = flag;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_MODE:  busRdata = CNT_W'(modeReg);
      ADDR_COUNT: busRdata = count;
      ADDR_FLAG:  busRdata = CNT_W'(flag);
      default:    busRdata = '0;
    endcase
  end

  p_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countEn && count != '1) |=> count == $past(count) + 1'b1);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.countEn |=> $stable(count));
  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countEn && count == '1 && !reloadMode) |=> count == '0);
  p_reload_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countEn && count == '1 && reloadMode) |=> count == $past(reloadReg));
  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.countEn && count == '1) |=> flag);
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flag) |-> $past(stb.clrFlag));
endmodule

// File: rtl/reload_timer8.sv
module reload_timer8
  import rtmr_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic              irqFlag
);
  tmrStrobes_t stb;
  logic [SEL_W-1:0] clkSel;
  logic fallEdge;

  rtmr_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .busAddr(busAddr), .busWr(busWr),
    .busWdata0(busWdata[0]), .clkSel(clkSel), .fallEdge(fallEdge), .stb(stb)
  );

  rtmr_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busAddr(busAddr), .busWdata(busWdata),
    .clkSel(clkSel), .fallEdge(fallEdge), .busRdata(busRdata), .irqFlag(irqFlag)
  );
endmodule

// File: tb/reload_timer8_bench.sv
module reload_timer8_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 7;
  localparam logic [7:0] V_MODE [NV] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06};
  localparam int V_WIN   [NV] = '{16384, 4096, 1024, 512, 128, 32, 8};
  localparam int V_DELTA [NV] = '{2, 2, 2, 2, 2, 2, 2};

  logic clk = 0, rstN = 0, evtIn = 0, busWr = 0, irqFlag;
  logic [1:0] busAddr = 0;
  logic [7:0] busWdata = 0, busRdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  reload_timer8 u_reload_timer8 (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .busAddr(busAddr), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .irqFlag(irqFlag)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // called at a negedge; returns at a negedge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1;
    @(negedge clk);
    busWr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; #1; d = busRdata;
  endtask

  task automatic pulse();
    evtIn = 1; repeat (3) @(negedge clk);
    evtIn = 0; repeat (3) @(negedge clk);
  endtask

  task automatic walkToFF();
    logic [7:0] c;
    rd(2'd1, c);
    while (c != 8'hFF) begin pulse(); rd(2'd1, c); end
  endtask

  initial begin
    logic [7:0] c0, c1, v;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    rd(2'd1, v); check(v, 8'h00, "R1 count");
    rd(2'd0, v); check(v, 8'h00, "R1 mode");
    rd(2'd2, v); check(v, 8'h00, "R1 flag");
    check({7'b0, irqFlag}, 8'h00, "R1 irqFlag");

    // R2 table of source codes
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, V_MODE[i]);
      rd(2'd1, c0);
      repeat (V_WIN[i]) @(negedge clk);
      rd(2'd1, c1);
      check(c1 - c0, 8'(V_DELTA[i]), $sformatf("R2 code %0d", i));
    end

    // R3 external rising
    wr(2'd0, 8'h07);
    rd(2'd0, v); check(v, 8'h07, "R10 mode readback");
    rd(2'd1, c0);
    evtIn = 1;
    repeat (2) @(negedge clk);
    rd(2'd1, c1); check(c1 - c0, 8'd0, "R3 latency two edges");
    @(negedge clk);
    rd(2'd1, c1); check(c1 - c0, 8'd1, "R3 rising counted");
    evtIn = 0; repeat (4) @(negedge clk);
    rd(2'd1, c1); check(c1 - c0, 8'd1, "R3 falling ignored");
    // R3 external falling
    wr(2'd0, 8'h17);
    rd(2'd0, v); check(v, 8'h17, "R10 edge bit readback");
    rd(2'd1, c0);
    evtIn = 1; repeat (4) @(negedge clk);
    rd(2'd1, c1); check(c1 - c0, 8'd0, "R3 rising ignored");
    evtIn = 0; repeat (3) @(negedge clk);
    rd(2'd1, c1); check(c1 - c0, 8'd1, "R3 falling counted");

    // R4 write to counter address goes to reload only
    wr(2'd0, 8'h07);
    rd(2'd1, c0);
    wr(2'd1, 8'h5A);
    rd(2'd1, c1); check(c1, c0, "R4 count unchanged");

    // R5 / R7 wrap
    walkToFF();
    rd(2'd2, v); check(v, 8'h00, "R7 no flag before overflow");
    pulse();
    rd(2'd1, v); check(v, 8'h00, "R5 wrap to zero");
    rd(2'd2, v); check(v, 8'h01, "R7 flag set");
    check({7'b0, irqFlag}, 8'h01, "R7 irqFlag");

    // R8 clear rules
    wr(2'd2, 8'h01);
    rd(2'd2, v); check(v, 8'h01, "R8 write 1 no effect");
    wr(2'd2, 8'h00);
    rd(2'd2, v); check(v, 8'h00, "R8 write 0 clears");

    // R6 reload
    wr(2'd0, 8'h0F);
    wr(2'd1, 8'hF0);
    walkToFF();
    pulse();
    rd(2'd1, v); check(v, 8'hF0, "R6 reload value");
    rd(2'd2, v); check(v, 8'h01, "R6 flag set");

    // R9 overflow and clear on the same edge
    walkToFF();
    evtIn = 1;
    repeat (2) @(negedge clk);
    wr(2'd2, 8'h00);
    rd(2'd1, v); check(v, 8'hF0, "R9 reload on coincident edge");
    rd(2'd2, v); check(v, 8'h01, "R9 overflow wins");
    evtIn = 0; repeat (3) @(negedge clk);
    wr(2'd2, 8'h00);
    rd(2'd2, v); check(v, 8'h00, "R8 clear after R9");

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule